// File: doc/BRIEF.md
# ULPI PHY-Side Bus Controller

This block is the transceiver end of a 12-pin low pin count USB link interface. It connects to the link through an 8-bit bidirectional data bus, a clock, a direction output, a throttle output and a stop input. While the link owns the bus, the block decodes command bytes. It forwards transmit bytes to a serializer through a valid/ready handshake, and it handles register writes and reads. When the block has something to report, it takes the bus over. It then drives received bytes, status bytes or register read data back to the link.

Only one party can use the shared bus at a time, so the block arbitrates between four sources in a fixed order. Received data comes first, then a transmit command, then a pending status report, then a register command. Every hand-over of the bus includes a one-cycle gap in which neither side drives. Line-state changes and host-disconnect changes raise status reports, and each of these two sources can be masked by a bit in an enable register.

Top module: `ulpi_phy_port`

## Requirements
- R1: During reset and in the first cycle after it, the direction output and the throttle output (nxt) are low, the block drives no bus value, and the serializer sees no valid byte.
- R2: A link byte of the form 01_xx_pppp, seen while idle with the serializer ready, is accepted with nxt high. In that same cycle the serializer receives the PID byte {~pppp, pppp}. Each later byte is forwarded to the serializer in the cycle where nxt is high.
- R3: While a transmit is in progress and the serializer is not ready, nxt stays low and no byte reaches the serializer. The link holds the byte until nxt goes high.
- R4: In a transmit cycle with stp high, nxt is low and no byte is forwarded. A one-cycle end-of-packet pulse goes to the serializer, and the block returns to idle.
- R5: The block drives the data bus only while the direction output is high. It does not drive in the cycle where the direction output rises, nor in the cycle where it falls.
- R6: When rx_active is seen while idle, the direction output rises in the next cycle, and the bus is driven one cycle after that. While the block drives, nxt is high only when it drives a received byte (rx_valid). In every other driving cycle the block sends a status byte with nxt low. When rx_active is seen low, the direction output falls in the next cycle.
- R7: A status byte carries the line state in bits [1:0] and an event code in bits [5:4]; all other bits are zero. The event codes are 10 for host disconnect (highest), 11 for receive active with error, 01 for receive active, and 00 for none.
- R8: Arbitration order is received data, then transmit command, then pending status report, then register command. A command that loses arbitration is not acknowledged with nxt.
- R9: A change of line state (source bit 0) or of host disconnect (source bit 1) whose enable bit is set makes the block take the bus and send one status byte. A masked change causes no bus takeover. The pending report clears once a status byte has been sent.
- R10: A link byte 10_aaaaaa is acknowledged with nxt. The next byte is also acknowledged with nxt and is written to address aaaaaa.
- R11: A link byte 11_aaaaaa is acknowledged with nxt. The direction output then rises for one turnaround cycle, the register value is driven in the following cycle, and the direction output falls after that.
- R12: Address 0 reads the constant 0xA5 and ignores writes. Address 1 is the enable register: bit 0 enables line-state reports, bit 1 enables disconnect reports, the reset value is 0x03, and the upper bits read 0. Addresses 2 and 3 are scratch registers with reset value 0. Higher addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ulpi_data | inout | 8 | Shared data bus |
| ulpi_dir | output | 1 | High while the block owns the bus |
| ulpi_nxt | output | 1 | Throttle / byte-accepted strobe |
| ulpi_stp | input | 1 | Link ends a transmit |
| ser_data | output | 8 | Byte to the serializer |
| ser_valid | output | 1 | ser_data is valid |
| ser_ready | input | 1 | Serializer can take a byte |
| ser_eop | output | 1 | Append end-of-packet |
| rx_active | input | 1 | Deserializer is receiving a packet |
| rx_valid | input | 1 | rx_data holds a received byte |
| rx_error | input | 1 | Receive error flagged |
| rx_data | input | 8 | Received byte |
| line_state | input | 2 | Current line state |
| host_disc | input | 1 | Host disconnect detected |

## Verification
The assertions check the bus ownership rules on every cycle: no driving without direction, no driving in a direction-change cycle, and nxt during receive only with a valid byte. They also check the transmit throttle and stop handling, and that a pending report only appears after an enabled source event. The bench scenarios are needed for everything that depends on data values or ordering over several cycles. This covers the PID byte form, status byte encodings, register map contents and masking, and which of two simultaneous requests wins arbitration.

// File: rtl/ulpi_phy_pkg.sv
package ulpi_phy_pkg;

  localparam int IRQ_W = 2;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_TX   = 2'b01,
    CMD_WR   = 2'b10,
    CMD_RD   = 2'b11
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_TXD, S_WDAT, S_UP, S_DRIVE, S_DOWN
  } state_e;

  typedef enum logic [1:0] {
    K_RX, K_STAT, K_REG
  } drv_kind_e;

  // serializer sees PID with its check nibble in the upper half
  function automatic logic [7:0] pid_byte(input logic [3:0] pid);
    return {~pid, pid};
  endfunction

  // status byte: [1:0] line state, [5:4] event code
  function automatic logic [7:0] status_byte(input logic [1:0] ls,
                                             input logic active,
                                             input logic err,
                                             input logic disc);
    logic [1:0] ev;
    if (disc)              ev = 2'b10;
    else if (active && err) ev = 2'b11;
    else if (active)       ev = 2'b01;
    else                   ev = 2'b00;
    return {2'b00, ev, 2'b00, ls};
  endfunction

endpackage

// File: rtl/ulpi_regfile.sv
module ulpi_regfile
  import ulpi_phy_pkg::*;
#(
  parameter int          NUM_REGS = 4,
  parameter logic [7:0]  ID_VAL   = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [5:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic [IRQ_W-1:0] irq_en
);
  localparam int         EN_ADDR = 1;
  localparam int         IDXW    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [5:0] LIMIT   = 6'(NUM_REGS);
  localparam logic [7:0] EN_MASK = 8'((1 << IRQ_W) - 1);

  logic [NUM_REGS-1:0][7:0] view;

  assign view[0] = ID_VAL;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] RST_V = (i == EN_ADDR) ? EN_MASK : 8'h00;
    localparam logic [7:0] KEEP  = (i == EN_ADDR) ? EN_MASK : 8'hFF;
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                        q <= RST_V;
      else if (wr_en && addr == 6'(i))   q <= wr_data & KEEP;
    end
    assign view[i] = q;
  end

  assign rd_data = (addr < LIMIT) ? view[addr[IDXW-1:0]] : 8'h00;
  assign irq_en  = view[EN_ADDR][IRQ_W-1:0];
endmodule

// File: rtl/ulpi_irq_track.sv
module ulpi_irq_track
  import ulpi_phy_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       line_state,
  input  logic             host_disc,
  input  logic [IRQ_W-1:0] irq_en,
  input  logic             clr,
  output logic [IRQ_W-1:0] evt,
  output logic             pend_any
);
  logic [1:0]       ls_q;
  logic             disc_q;
  logic [IRQ_W-1:0] pend_q;

  assign evt = {host_disc ^ disc_q, |(line_state ^ ls_q)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ls_q   <= line_state;
      disc_q <= host_disc;
      pend_q <= '0;
    end else begin
      ls_q   <= line_state;
      disc_q <= host_disc;
      pend_q <= (pend_q & ~{IRQ_W{clr}}) | (evt & irq_en);
    end
  end

  assign pend_any = |pend_q;
endmodule

// File: rtl/ulpi_bus_fsm.sv
module ulpi_bus_fsm
  import ulpi_phy_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_in,
  input  logic       stp,
  input  logic       rx_active,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic [7:0] stat_byte,
  input  logic       pend_any,
  input  logic       ser_ready,
  input  logic [7:0] reg_rd_data,
  output logic       dir,
  output logic       nxt,
  output logic       drive_en,
  output logic [7:0] bus_out,
  output logic       ser_valid,
  output logic [7:0] ser_data,
  output logic       ser_eop,
  output logic       reg_wr_en,
  output logic [5:0] reg_addr,
  output logic       irq_clr,
  output logic       tx_busy
);
  state_e    st_q, st_d;
  drv_kind_e kind_q, kind_d;
  logic [5:0] addr_q, addr_d;
  cmd_e      cmd;

  assign cmd = cmd_e'(bus_in[7:6]);

  always_comb begin
    st_d = st_q; kind_d = kind_q; addr_d = addr_q;
    dir = 1'b0; nxt = 1'b0; drive_en = 1'b0; bus_out = 8'h00;
    ser_valid = 1'b0; ser_data = 8'h00; ser_eop = 1'b0;
    reg_wr_en = 1'b0; irq_clr = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (rx_active) begin
          st_d = S_UP; kind_d = K_RX;
        end else if (cmd == CMD_TX) begin
          nxt = ser_ready; ser_valid = ser_ready;
          ser_data = pid_byte(bus_in[3:0]);
          if (ser_ready) st_d = S_TXD;
        end else if (pend_any) begin
          st_d = S_UP; kind_d = K_STAT;
        end else if (cmd == CMD_WR) begin
          nxt = 1'b1; addr_d = bus_in[5:0]; st_d = S_WDAT;
        end else if (cmd == CMD_RD) begin
          nxt = 1'b1; addr_d = bus_in[5:0]; st_d = S_UP; kind_d = K_REG;
        end
      end
      S_TXD: begin
        if (stp) begin
          ser_eop = 1'b1; st_d = S_IDLE;
        end else begin
          nxt = ser_ready; ser_valid = ser_ready; ser_data = bus_in;
        end
      end
      S_WDAT: begin
        nxt = 1'b1; reg_wr_en = 1'b1; st_d = S_IDLE;
      end
      S_UP: begin
        dir = 1'b1; st_d = S_DRIVE;
      end
      S_DRIVE: begin
        dir = 1'b1; drive_en = 1'b1;
        unique case (kind_q)
          K_RX: begin
            if (rx_active && rx_valid) begin
              bus_out = rx_data; nxt = 1'b1;
            end else begin
              bus_out = stat_byte; irq_clr = 1'b1;
            end
            if (!rx_active) st_d = S_DOWN;
          end
          K_STAT: begin
            bus_out = stat_byte; irq_clr = 1'b1; st_d = S_DOWN;
          end
          default: begin
            bus_out = reg_rd_data; st_d = S_DOWN;
          end
        endcase
      end
      default: st_d = S_IDLE;  // S_DOWN: link-side turnaround
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; kind_q <= K_RX; addr_q <= '0;
    end else begin
      st_q <= st_d; kind_q <= kind_d; addr_q <= addr_d;
    end
  end

  assign reg_addr = addr_q;
  assign tx_busy  = (st_q == S_TXD);
endmodule

// File: rtl/ulpi_phy_port.sv
module ulpi_phy_port
  import ulpi_phy_pkg::*;
#(
  parameter int         NUM_REGS = 4,
  parameter logic [7:0] ID_VAL   = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  inout  wire  [7:0] ulpi_data,
  output logic       ulpi_dir,
  output logic       ulpi_nxt,
  input  logic       ulpi_stp,
  output logic [7:0] ser_data,
  output logic       ser_valid,
  input  logic       ser_ready,
  output logic       ser_eop,
  input  logic       rx_active,
  input  logic       rx_valid,
  input  logic       rx_error,
  input  logic [7:0] rx_data,
  input  logic [1:0] line_state,
  input  logic       host_disc
);
  logic [7:0]       bus_in, bus_out, reg_rd_data, stat_b;
  logic             drv_en, reg_wr_en, irq_clr, irq_pend_any, tx_busy;
  logic [5:0]       reg_addr;
  logic [IRQ_W-1:0] irq_en, irq_evt;

  assign ulpi_data = drv_en ? bus_out : 8'hzz;
  assign bus_in    = ulpi_data;
  assign stat_b    = status_byte(line_state, rx_active, rx_error, host_disc);

  ulpi_regfile #(.NUM_REGS(NUM_REGS), .ID_VAL(ID_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wr_data(bus_in), .rd_data(reg_rd_data), .irq_en(irq_en)
  );

  ulpi_irq_track u_irq (
    .clk(clk), .rst_n(rst_n), .line_state(line_state), .host_disc(host_disc),
    .irq_en(irq_en), .clr(irq_clr), .evt(irq_evt), .pend_any(irq_pend_any)
  );

  ulpi_bus_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .stp(ulpi_stp),
    .rx_active(rx_active), .rx_valid(rx_valid), .rx_data(rx_data),
    .stat_byte(stat_b), .pend_any(irq_pend_any), .ser_ready(ser_ready),
    .reg_rd_data(reg_rd_data), .dir(ulpi_dir), .nxt(ulpi_nxt),
    .drive_en(drv_en), .bus_out(bus_out), .ser_valid(ser_valid),
    .ser_data(ser_data), .ser_eop(ser_eop), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .irq_clr(irq_clr), .tx_busy(tx_busy)
  );
endmodule

// File: rtl/ulpi_phy_port_chk.sv
module ulpi_phy_port_chk
  import ulpi_phy_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             dir,
  input logic             nxt,
  input logic             drive_en,
  input logic             stp,
  input logic             ser_valid,
  input logic             ser_ready,
  input logic             ser_eop,
  input logic             rx_valid,
  input logic             tx_busy,
  input logic [IRQ_W-1:0] evt_vec,
  input logic [IRQ_W-1:0] irq_en,
  input logic             pend_any
);
  // R5
  drive_needs_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> dir);

  // R5
  turnaround_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir != $past(dir)) |-> !drive_en);

  // R6
  rx_nxt_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && nxt) |-> rx_valid);

  // R3
  tx_throttle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !stp && !ser_ready) |-> (!nxt && !ser_valid));

  // R4
  stop_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && stp) |-> (ser_eop && !nxt && !ser_valid));

  // R4
  eop_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_eop |=> !tx_busy);

  // R9
  pend_from_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_any) |-> ($past(evt_vec & irq_en) != '0));
endmodule

bind ulpi_phy_port ulpi_phy_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dir(ulpi_dir), .nxt(ulpi_nxt), .drive_en(drv_en),
  .stp(ulpi_stp), .ser_valid(ser_valid), .ser_ready(ser_ready),
  .ser_eop(ser_eop), .rx_valid(rx_valid), .tx_busy(tx_busy),
  .evt_vec(irq_evt), .irq_en(irq_en), .pend_any(irq_pend_any)
);

// File: tb/test_ulpi_phy_port.sv
module test_ulpi_phy_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_en = 1'b1;
  logic [7:0] link_val = 8'h00;
  logic stp = 1'b0, ser_ready = 1'b1;
  logic rx_active = 1'b0, rx_valid = 1'b0, rx_error = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [1:0] line_state = 2'b01;
  logic host_disc = 1'b0;
  wire  [7:0] ulpi_data;
  logic dir, nxt, ser_valid, ser_eop;
  logic [7:0] ser_data;
  int vectors = 0, miscompares = 0;

  always #4 clk = ~clk;  // 125 MHz

  assign ulpi_data = (link_en && !dir) ? link_val : 8'hzz;

  ulpi_phy_port i_ulpi_phy_port (
    .clk(clk), .rst_n(rst_n), .ulpi_data(ulpi_data), .ulpi_dir(dir),
    .ulpi_nxt(nxt), .ulpi_stp(stp), .ser_data(ser_data), .ser_valid(ser_valid),
    .ser_ready(ser_ready), .ser_eop(ser_eop), .rx_active(rx_active),
    .rx_valid(rx_valid), .rx_error(rx_error), .rx_data(rx_data),
    .line_state(line_state), .host_disc(host_disc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #2; endtask
  task automatic look(); #1; endtask

  task automatic reg_wr(input logic [5:0] a, input logic [7:0] d);
    link_val = {2'b10, a}; look(); chk("R10 cmd nxt", nxt, 1);
    step(); link_val = d; look(); chk("R10 data nxt", nxt, 1);
    step(); link_val = 8'h00;
  endtask

  task automatic reg_rd(input logic [5:0] a, input logic [7:0] exp, input string req);
    link_val = {2'b11, a}; look();
    chk("R11 cmd nxt", nxt, 1); chk("R11 dir low", dir, 0);
    step(); link_val = 8'h00; look();
    chk("R11 R5 turnaround dir", dir, 1); chk("R11 turnaround nxt", nxt, 0);
    step(); look(); chk("R11 dir", dir, 1); chk(req, ulpi_data, exp);
    step(); look(); chk("R11 R5 dir fall", dir, 0);
    step();
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    look(); chk("R1 dir in reset", dir, 0); chk("R1 nxt in reset", nxt, 0);
    #1 rst_n = 1'b1; step(); look();
    chk("R1 dir", dir, 0); chk("R1 nxt", nxt, 0); chk("R1 ser_valid", ser_valid, 0);
  endtask

  task automatic t_regmap();
    reg_rd(6'd0, 8'hA5, "R12 id");
    reg_wr(6'd0, 8'hFF); reg_rd(6'd0, 8'hA5, "R12 id read-only");
    reg_rd(6'd1, 8'h03, "R12 enable reset");
    reg_wr(6'd1, 8'hFE); reg_rd(6'd1, 8'h02, "R12 enable upper bits");
    reg_wr(6'd1, 8'h03);
    reg_rd(6'd3, 8'h00, "R12 scratch reset");
    reg_wr(6'd3, 8'h77); reg_rd(6'd3, 8'h77, "R10 R12 scratch write");
    reg_wr(6'd9, 8'h12); reg_rd(6'd9, 8'h00, "R12 unmapped");
  endtask

  task automatic t_tx();
    ser_ready = 1'b1; link_val = 8'h43; look();
    chk("R2 cmd nxt", nxt, 1); chk("R2 pid valid", ser_valid, 1); chk("R2 pid byte", ser_data, 8'hC3);
    step(); link_val = 8'h11; look();
    chk("R2 data nxt", nxt, 1); chk("R2 data", ser_data, 8'h11);
    step(); link_val = 8'h22; ser_ready = 1'b0; look();
    chk("R3 nxt low", nxt, 0); chk("R3 no byte", ser_valid, 0);
    step(); ser_ready = 1'b1; look();
    chk("R3 resume nxt", nxt, 1); chk("R3 held byte", ser_data, 8'h22);
    step(); link_val = 8'h00; stp = 1'b1; look();
    chk("R4 nxt", nxt, 0); chk("R4 eop", ser_eop, 1); chk("R4 no byte", ser_valid, 0);
    step(); stp = 1'b0; look();
    chk("R4 eop pulse", ser_eop, 0); chk("R4 idle dir", dir, 0);
    step();
  endtask

  task automatic t_rx();
    rx_active = 1'b1; look(); chk("R6 dir not yet", dir, 0);
    step(); look(); chk("R6 R5 dir up", dir, 1); chk("R6 nxt in turnaround", nxt, 0);
    step(); look(); chk("R6 R7 status active", ulpi_data, 8'h11); chk("R6 status nxt", nxt, 0);
    rx_valid = 1'b1; rx_data = 8'h3C; look();
    chk("R6 rx nxt", nxt, 1); chk("R6 rx byte", ulpi_data, 8'h3C);
    step(); rx_data = 8'h4D; look(); chk("R6 rx byte 2", ulpi_data, 8'h4D);
    step(); rx_valid = 1'b0; rx_error = 1'b1; look();
    chk("R7 error code", ulpi_data, 8'h31); chk("R6 nxt no byte", nxt, 0);
    step(); rx_active = 1'b0; rx_error = 1'b0; look();
    chk("R7 no event", ulpi_data, 8'h01); chk("R6 still dir", dir, 1);
    step(); look(); chk("R6 R5 dir fall", dir, 0);
    step();
  endtask

  task automatic t_prio_rx_tx();
    link_val = 8'h45; rx_active = 1'b1; look();
    chk("R8 rx beats tx nxt", nxt, 0); chk("R8 rx beats tx valid", ser_valid, 0);
    step(); link_val = 8'h00; rx_active = 1'b0; look(); chk("R8 dir up", dir, 1);
    step(); step(); step(); look(); chk("R8 back idle", dir, 0);
  endtask

  task automatic t_irq();
    line_state = 2'b10; look(); chk("R9 dir before", dir, 0);
    step(); look(); chk("R9 dir pending", dir, 0);
    step(); look(); chk("R9 dir up", dir, 1);
    step(); look(); chk("R9 R7 status byte", ulpi_data, 8'h02); chk("R9 nxt", nxt, 0);
    step(); look(); chk("R9 dir fall", dir, 0);
    step(); step(); look(); chk("R9 cleared", dir, 0);
  endtask

  task automatic t_mask_and_disc();
    reg_wr(6'd1, 8'h02);
    line_state = 2'b01;
    for (int k = 0; k < 4; k++) begin step(); look(); chk("R9 masked", dir, 0); end
    host_disc = 1'b1; step(); link_val = 8'hC1; look();
    chk("R8 status beats reg cmd", nxt, 0);
    step(); link_val = 8'h00; look(); chk("R9 disc dir", dir, 1);
    step(); look(); chk("R7 disconnect code", ulpi_data, 8'h21);
    step(); step();
    reg_rd(6'd1, 8'h02, "R12 enable after mask write");
    reg_wr(6'd1, 8'h03);
  endtask

  task automatic t_prio_tx_irq();
    host_disc = 1'b0; step(); link_val = 8'h41; ser_ready = 1'b1; look();
    chk("R8 tx beats status nxt", nxt, 1); chk("R8 R2 pid", ser_data, 8'hE1);
    step(); link_val = 8'h00; stp = 1'b1; look(); chk("R8 R4 eop", ser_eop, 1);
    step(); stp = 1'b0; look(); chk("R8 dir idle", dir, 0);
    step(); look(); chk("R8 status after tx", dir, 1);
    step(); look(); chk("R8 R7 status", ulpi_data, 8'h01);
    step(); step(); look(); chk("R8 end", dir, 0);
  endtask

  initial begin
    t_reset();
    t_regmap();
    t_tx();
    t_rx();
    t_prio_rx_tx();
    t_irq();
    t_mask_and_disc();
    t_prio_tx_irq();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule